// File: doc/BRIEF.md
# Sectioned Clock Register Access Unit

This block is the register layer of a real-time clock whose settings are kept in non-volatile storage. It sits behind a byte-serial bus front end that has already decoded the bus into single-cycle events: start (with a read or write flag), address, write byte, read request and stop. The block holds two alarm sections, a control section and a status register. It presents the time registers of an external time counter.

Each operation works inside one register section. The access pointer moves forward after every byte and wraps to the first address of its section. A read operation freezes a copy of the live time when it starts, so a tick during the read does not tear the value. Written bytes are held in a buffer and are committed only by a proper stop. Alarm, control and time bytes also need the register write-enable bit in status. A time commit is handed to the time counter as a one-cycle load with a byte mask.

Top module: `rtc_regaccess`

## Requirements
- R1: After reset, status reads 01h. The century bytes of both alarm sections (addresses 07h and 0Fh) read 20h. Every other alarm and control byte reads 00h.
- R2: Sections are alarm0 00h-07h, alarm1 08h-0Fh, control 10h-13h, time 30h-37h and status 3Fh. A read or write past the last address of a section continues at that section's first address.
- R3: An operation may begin at any address. After a read, the pointer holds the next address in the section, so a read operation that starts with no address byte continues from there.
- R4: Starting a read operation captures the 64-bit live time input. Time address 30h+k returns bits [8k+7:8k] of that capture, whatever the live input does later.
- R5: Writes to alarm, control or time bytes take effect only at a stop, and only if status bit 2 (register write enable) is 1 at that stop. Otherwise they are discarded.
- R6: A write operation that ends with a new start instead of a stop discards its buffered bytes.
- R7: A committed time write raises `tm_load` for exactly one cycle, in the cycle after the stop. `tm_load_mask` bit k marks the written offsets and `tm_load_data[8k+7:8k]` holds byte k.
- R8: Status (bit 7 battery, 6 alarm1, 5 alarm0, 2 register write enable, 1 write enable, 0 clock-fail) is written at a stop without needing the write enable. Bits 4:3 always read 0. A second data byte to status in the same operation ends that operation. That byte is ignored, produces no `rd_vld`, and any pending status write is dropped.
- R9: Addresses outside every section read 00h, ignore writes, and advance the pointer by one.
- R10: A read request in an active read operation gives `rd_vld` high for one cycle, in the cycle after the request, with `rd_data` valid. No request, no `rd_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start (or repeated start) event |
| bus_start_rd | input | 1 | With bus_start: 1 = read operation, 0 = write operation |
| bus_addr_vld | input | 1 | Address byte event (write operations only) |
| bus_addr | input | 8 | Register address |
| bus_wr_vld | input | 1 | Data byte written by the bus master |
| bus_wdata | input | 8 | Written byte |
| bus_rd_req | input | 1 | Request for the next read byte |
| bus_stop | input | 1 | Stop event |
| rd_data | output | 8 | Read byte |
| rd_vld | output | 1 | rd_data valid pulse |
| tm_live | input | 64 | Live time value, byte k = address 30h+k |
| tm_load | output | 1 | One-cycle load strobe to the time counter |
| tm_load_data | output | 64 | Bytes to load |
| tm_load_mask | output | 8 | Which bytes to load |

## Verification
The hardest state to reach is a status operation that receives a second byte. The front end has to deliver a status address and two data bytes in one operation, and then a stop that must not commit anything. The bench drives that sequence directly. It then reads status back to show that neither byte landed. A matching read sequence shows that the second request returns no `rd_vld`. The frozen-time case is reached by changing `tm_live` between the read start and each byte request.

// File: rtl/rtc_ra_pkg.sv
package rtc_ra_pkg;

    localparam int AW       = 8;
    localparam int DW       = 8;
    localparam int SEC_MAX  = 8;
    localparam int OFS_W    = $clog2(SEC_MAX);
    localparam int TIME_W   = SEC_MAX * DW;
    localparam int CFG_N    = 20;

    localparam logic [AW-1:0] AL0_FIRST  = 8'h00;
    localparam logic [AW-1:0] AL0_LAST   = 8'h07;
    localparam logic [AW-1:0] AL1_FIRST  = 8'h08;
    localparam logic [AW-1:0] AL1_LAST   = 8'h0F;
    localparam logic [AW-1:0] CTL_FIRST  = 8'h10;
    localparam logic [AW-1:0] CTL_LAST   = 8'h13;
    localparam logic [AW-1:0] TIME_FIRST = 8'h30;
    localparam logic [AW-1:0] TIME_LAST  = 8'h37;
    localparam logic [AW-1:0] STAT_ADDR  = 8'h3F;

    localparam int            ST_REGWE_BIT = 2;
    localparam logic [DW-1:0] ST_WMASK     = 8'hE7;
    localparam logic [DW-1:0] ST_RESET     = 8'h01;
    localparam logic [DW-1:0] CENTURY_RST  = 8'h20;
    localparam int            CENTURY_OFS  = 7;

    typedef enum logic [2:0] {
        SEC_NONE, SEC_AL0, SEC_AL1, SEC_CTL, SEC_TIME, SEC_STAT
    } sec_e;

    typedef struct packed {
        logic          start;
        logic          start_rd;
        logic          addr_vld;
        logic [AW-1:0] addr;
        logic          wr_vld;
        logic [DW-1:0] wdata;
        logic          rd_req;
        logic          stop;
    } bus_ev_t;

    typedef struct packed {
        logic               go;
        sec_e               sec;
        logic [SEC_MAX-1:0] mask;
        logic [TIME_W-1:0]  data;
    } commit_t;

    function automatic sec_e sec_of(input logic [AW-1:0] a);
        if (a <= AL0_LAST)                        return SEC_AL0;
        else if (a <= AL1_LAST)                   return SEC_AL1;
        else if (a >= CTL_FIRST && a <= CTL_LAST) return SEC_CTL;
        else if (a >= TIME_FIRST && a <= TIME_LAST) return SEC_TIME;
        else if (a == STAT_ADDR)                  return SEC_STAT;
        return SEC_NONE;
    endfunction

    function automatic logic [AW-1:0] sec_first(input sec_e s);
        case (s)
            SEC_AL1:  return AL1_FIRST;
            SEC_CTL:  return CTL_FIRST;
            SEC_TIME: return TIME_FIRST;
            SEC_STAT: return STAT_ADDR;
            default:  return AL0_FIRST;
        endcase
    endfunction

    function automatic logic [AW-1:0] sec_last(input sec_e s);
        case (s)
            SEC_AL1:  return AL1_LAST;
            SEC_CTL:  return CTL_LAST;
            SEC_TIME: return TIME_LAST;
            SEC_STAT: return STAT_ADDR;
            default:  return AL0_LAST;
        endcase
    endfunction

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] a);
        sec_e s;
        s = sec_of(a);
        if (s != SEC_NONE && a == sec_last(s)) return sec_first(s);
        return a + 8'd1;
    endfunction

endpackage

// File: rtl/rtc_ra_ctrl.sv
module rtc_ra_ctrl
    import rtc_ra_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    output logic [AW-1:0] ptr,
    output logic          acc_wr,
    output logic          acc_rd,
    output logic          commit_req,
    output logic          flush,
    output logic          snap_req
);
    logic op_act, op_rd, touched;
    logic plain, st_block, abort;

    assign plain    = op_act && !ev.start && !ev.stop && !ev.addr_vld;
    assign st_block = (sec_of(ptr) == SEC_STAT) && touched;
    assign acc_wr   = plain && !op_rd && ev.wr_vld && !st_block;
    assign acc_rd   = plain && op_rd && ev.rd_req && !st_block;
    assign abort    = plain && st_block &&
                      ((!op_rd && ev.wr_vld) || (op_rd && ev.rd_req));
    assign commit_req = ev.stop && op_act && !op_rd && !ev.start;
    assign flush    = ev.start || ev.stop || abort;
    assign snap_req = ev.start && ev.start_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            op_act  <= 1'b0;
            op_rd   <= 1'b0;
            touched <= 1'b0;
        end else if (ev.start) begin
            op_act  <= 1'b1;
            op_rd   <= ev.start_rd;
            touched <= 1'b0;
        end else if (ev.stop || abort) begin
            op_act  <= 1'b0;
        end else if (ev.addr_vld && op_act && !op_rd) begin
            ptr     <= ev.addr;
            touched <= 1'b0;
        end else if (acc_wr || acc_rd) begin
            ptr     <= ptr_next(ptr);
            touched <= 1'b1;
        end
    end
endmodule

// File: rtl/rtc_ra_wbuf.sv
module rtc_ra_wbuf
    import rtc_ra_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_wr,
    input  logic [AW-1:0] ptr,
    input  logic [DW-1:0] wdata,
    input  logic          flush,
    input  logic          commit_req,
    input  logic          regwe,
    output commit_t       cm
);
    logic [TIME_W-1:0]  data_q;
    logic [SEC_MAX-1:0] mask_q;
    sec_e               sec_q;
    sec_e               wsec;
    logic [OFS_W-1:0]   ofs;

    assign wsec = sec_of(ptr);
    assign ofs  = ptr[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            mask_q <= '0;
            sec_q  <= SEC_NONE;
        end else if (flush) begin
            mask_q <= '0;
        end else if (acc_wr && wsec != SEC_NONE) begin
            data_q[ofs*DW +: DW] <= wdata;
            mask_q[ofs]          <= 1'b1;
            sec_q                <= wsec;
        end
    end

    always_comb begin
        cm.go   = commit_req && (|mask_q) && (sec_q == SEC_STAT || regwe);
        cm.sec  = sec_q;
        cm.mask = mask_q;
        cm.data = data_q;
    end
endmodule

// File: rtl/rtc_ra_store.sv
module rtc_ra_store
    import rtc_ra_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  commit_t            cm,
    input  logic               snap_req,
    input  logic [TIME_W-1:0]  tm_live,
    input  logic               acc_rd,
    input  logic [AW-1:0]      ptr,
    output logic [DW-1:0]      rd_data,
    output logic               rd_vld,
    output logic [DW-1:0]      status,
    output logic               tm_load,
    output logic [TIME_W-1:0]  tm_load_data,
    output logic [SEC_MAX-1:0] tm_load_mask
);
    logic [DW-1:0]     cfg [CFG_N];
    logic [TIME_W-1:0] snap_q;
    logic [DW-1:0]     st_q;
    logic [DW-1:0]     mux;

    for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
        localparam sec_e          G_SEC = (g < 8) ? SEC_AL0 : ((g < 16) ? SEC_AL1 : SEC_CTL);
        localparam int            G_OFS = g % SEC_MAX;
        localparam logic [DW-1:0] G_RST = (g < 16 && G_OFS == CENTURY_OFS) ? CENTURY_RST : 8'h00;
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= G_RST;
            else if (cm.go && cm.sec == G_SEC && cm.mask[G_OFS])
                q <= cm.data[G_OFS*DW +: DW];
        end
        assign cfg[g] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_RESET;
            snap_q       <= '0;
            tm_load      <= 1'b0;
            tm_load_data <= '0;
            tm_load_mask <= '0;
        end else begin
            if (cm.go && cm.sec == SEC_STAT)
                st_q <= cm.data[CENTURY_OFS*DW +: DW] & ST_WMASK;
            if (snap_req)
                snap_q <= tm_live;
            tm_load <= cm.go && cm.sec == SEC_TIME;
            if (cm.go && cm.sec == SEC_TIME) begin
                tm_load_data <= cm.data;
                tm_load_mask <= cm.mask;
            end
        end
    end

    always_comb begin
        case (sec_of(ptr))
            SEC_AL0, SEC_AL1, SEC_CTL: mux = cfg[ptr[4:0]];
            SEC_TIME:                  mux = snap_q[ptr[OFS_W-1:0]*DW +: DW];
            SEC_STAT:                  mux = st_q;
            default:                   mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= acc_rd;
            if (acc_rd) rd_data <= mux;
        end
    end

    assign status = st_q;
endmodule

// File: rtl/rtc_regaccess.sv
module rtc_regaccess
    import rtc_ra_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_start,
    input  logic               bus_start_rd,
    input  logic               bus_addr_vld,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_wr_vld,
    input  logic [DW-1:0]      bus_wdata,
    input  logic               bus_rd_req,
    input  logic               bus_stop,
    output logic [DW-1:0]      rd_data,
    output logic               rd_vld,
    input  logic [TIME_W-1:0]  tm_live,
    output logic               tm_load,
    output logic [TIME_W-1:0]  tm_load_data,
    output logic [SEC_MAX-1:0] tm_load_mask
);
    bus_ev_t       ev;
    logic [AW-1:0] ptr_q;
    logic          acc_wr, acc_rd, commit_req, flush, snap_req;
    commit_t       cm;
    logic [DW-1:0] st_q;

    always_comb begin
        ev.start    = bus_start;
        ev.start_rd = bus_start_rd;
        ev.addr_vld = bus_addr_vld;
        ev.addr     = bus_addr;
        ev.wr_vld   = bus_wr_vld;
        ev.wdata    = bus_wdata;
        ev.rd_req   = bus_rd_req;
        ev.stop     = bus_stop;
    end

    rtc_ra_ctrl u_ctrl (
        .clk(clk), .rst(rst), .ev(ev), .ptr(ptr_q),
        .acc_wr(acc_wr), .acc_rd(acc_rd), .commit_req(commit_req),
        .flush(flush), .snap_req(snap_req)
    );

    rtc_ra_wbuf u_wbuf (
        .clk(clk), .rst(rst), .acc_wr(acc_wr), .ptr(ptr_q), .wdata(bus_wdata),
        .flush(flush), .commit_req(commit_req), .regwe(st_q[ST_REGWE_BIT]), .cm(cm)
    );

    rtc_ra_store u_store (
        .clk(clk), .rst(rst), .cm(cm), .snap_req(snap_req), .tm_live(tm_live),
        .acc_rd(acc_rd), .ptr(ptr_q), .rd_data(rd_data), .rd_vld(rd_vld),
        .status(st_q), .tm_load(tm_load), .tm_load_data(tm_load_data),
        .tm_load_mask(tm_load_mask)
    );
endmodule

// File: rtl/rtc_ra_chk.sv
module rtc_ra_chk
    import rtc_ra_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_stop,
    input logic          bus_rd_req,
    input logic          rd_vld,
    input logic          tm_load,
    input logic [DW-1:0] status,
    input logic [AW-1:0] ptr,
    input logic          adv
);
    a_r7_load_after_stop: assert property (@(posedge clk) disable iff (rst)
        tm_load |-> $past(bus_stop));

    a_r7_load_single: assert property (@(posedge clk) disable iff (rst)
        tm_load |=> !tm_load);

    a_r10_vld_after_req: assert property (@(posedge clk) disable iff (rst)
        rd_vld |-> $past(bus_rd_req));

    a_r8_status_gap_zero: assert property (@(posedge clk) disable iff (rst)
        status[4:3] == 2'b00);

    a_r2_ptr_in_section: assert property (@(posedge clk) disable iff (rst)
        (adv && sec_of(ptr) != SEC_NONE) |=> sec_of(ptr) == $past(sec_of(ptr)));
endmodule

bind rtc_regaccess rtc_ra_chk u_chk (
    .clk(clk), .rst(rst), .bus_stop(bus_stop), .bus_rd_req(bus_rd_req),
    .rd_vld(rd_vld), .tm_load(tm_load), .status(st_q), .ptr(ptr_q),
    .adv(acc_wr || acc_rd)
);

// File: tb/test_rtc_regaccess.sv
module test_rtc_regaccess;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        b_start = 0, b_start_rd = 0, b_addr_vld = 0, b_wr = 0, b_rd = 0, b_stop = 0;
    logic [7:0]  b_addr = 0, b_wdata = 0;
    logic [7:0]  rd_data;
    logic        rd_vld;
    logic [63:0] tm_live = 64'h0;
    logic        tm_load;
    logic [63:0] tm_load_data;
    logic [7:0]  tm_load_mask;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    rtc_regaccess i_rtc_regaccess (
        .clk(clk), .rst(rst), .bus_start(b_start), .bus_start_rd(b_start_rd),
        .bus_addr_vld(b_addr_vld), .bus_addr(b_addr), .bus_wr_vld(b_wr),
        .bus_wdata(b_wdata), .bus_rd_req(b_rd), .bus_stop(b_stop),
        .rd_data(rd_data), .rd_vld(rd_vld), .tm_live(tm_live),
        .tm_load(tm_load), .tm_load_data(tm_load_data), .tm_load_mask(tm_load_mask)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ev_start(input logic rd);
        @(negedge clk); b_start = 1; b_start_rd = rd;
        @(negedge clk); b_start = 0; b_start_rd = 0;
    endtask
    task automatic ev_addr(input logic [7:0] a);
        @(negedge clk); b_addr_vld = 1; b_addr = a;
        @(negedge clk); b_addr_vld = 0;
    endtask
    task automatic ev_wr(input logic [7:0] d);
        @(negedge clk); b_wr = 1; b_wdata = d;
        @(negedge clk); b_wr = 0;
    endtask
    task automatic ev_rd(output logic [7:0] d, output logic v);
        @(negedge clk); b_rd = 1;
        @(negedge clk); b_rd = 0; d = rd_data; v = rd_vld;
    endtask
    task automatic ev_stop(output logic ld);
        @(negedge clk); b_stop = 1;
        @(negedge clk); b_stop = 0; ld = tm_load;
    endtask

    task automatic rd_expect(input string req, input logic [7:0] exp);
        logic [7:0] d; logic v;
        ev_rd(d, v);
        chk({req, " vld"}, v, 1'b1);
        chk(req, d, exp);
    endtask

    task automatic read_one(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic ld;
        ev_start(0); ev_addr(a); ev_start(1);
        rd_expect(req, exp);
        ev_stop(ld);
    endtask

    task automatic write_one(input logic [7:0] a, input logic [7:0] d, output logic ld);
        ev_start(0); ev_addr(a); ev_wr(d); ev_stop(ld);
    endtask

    task automatic t_reset;
        logic ld;
        ev_start(0); ev_addr(8'h00); ev_start(1);
        for (int i = 0; i < 8; i++) rd_expect("R1 alarm0", (i == 7) ? 8'h20 : 8'h00);
        ev_stop(ld);
        read_one("R1 alarm1 century", 8'h0F, 8'h20);
        read_one("R1 control", 8'h12, 8'h00);
        read_one("R1 status", 8'h3F, 8'h01);
        chk("R10 idle no vld", rd_vld, 1'b0);
    endtask

    task automatic t_locked;
        logic ld;
        write_one(8'h11, 8'hAA, ld);
        read_one("R5 locked control write", 8'h11, 8'h00);
        write_one(8'h30, 8'h99, ld);
        chk("R5 locked time no load", ld, 1'b0);
    endtask

    task automatic t_status;
        logic ld;
        write_one(8'h3F, 8'hFF, ld);
        read_one("R8 status no regwe needed, bits4:3 zero", 8'h3F, 8'hE7);
        write_one(8'h3F, 8'h06, ld);
        read_one("R8 status set regwe", 8'h3F, 8'h06);
    endtask

    task automatic t_wrap;
        logic ld;
        ev_start(0); ev_addr(8'h10);
        ev_wr(8'h11); ev_wr(8'h22); ev_wr(8'h33); ev_wr(8'h44); ev_wr(8'h55);
        ev_stop(ld);
        ev_start(0); ev_addr(8'h12); ev_start(1);
        rd_expect("R2 ctl 12h", 8'h33);
        rd_expect("R2 ctl 13h", 8'h44);
        rd_expect("R5 R2 ctl 10h wrapped write", 8'h55);
        rd_expect("R2 ctl 11h", 8'h22);
        ev_stop(ld);
        ev_start(1);
        rd_expect("R3 current address continues", 8'h33);
        ev_stop(ld);
    endtask

    task automatic t_nostop;
        logic ld;
        ev_start(0); ev_addr(8'h05); ev_wr(8'h77);
        ev_start(0); ev_stop(ld);
        read_one("R6 repeated start discards", 8'h05, 8'h00);
    endtask

    task automatic t_snapshot;
        logic ld;
        logic [63:0] frozen;
        frozen = 64'h3726_1508_0415_3045;
        tm_live = frozen;
        ev_start(0); ev_addr(8'h30); ev_start(1);
        for (int i = 0; i < 8; i++) begin
            tm_live = ~frozen + 64'(i);
            rd_expect("R4 snapshot byte", frozen[i*8 +: 8]);
        end
        rd_expect("R4 R2 time wrap", frozen[7:0]);
        ev_stop(ld);
    endtask

    task automatic t_timeload;
        logic ld;
        ev_start(0); ev_addr(8'h32); ev_wr(8'hA1); ev_wr(8'hB2); ev_stop(ld);
        chk("R7 load pulse", ld, 1'b1);
        chk("R7 load mask", tm_load_mask, 8'h0C);
        chk("R7 load data", tm_load_data[31:16], 16'hB2A1);
        @(negedge clk);
        chk("R7 load single cycle", tm_load, 1'b0);
        ev_start(0); ev_addr(8'h37); ev_wr(8'hC3); ev_wr(8'hD4); ev_stop(ld);
        chk("R7 R2 wrapped load mask", tm_load_mask, 8'h81);
        chk("R7 wrapped data", {tm_load_data[63:56], tm_load_data[7:0]}, 16'hC3D4);
    endtask

    task automatic t_status_second;
        logic ld; logic [7:0] d; logic v;
        ev_start(0); ev_addr(8'h3F); ev_wr(8'h01); ev_wr(8'h02); ev_stop(ld);
        read_one("R8 second status byte drops write", 8'h3F, 8'h06);
        ev_start(0); ev_addr(8'h3F); ev_start(1);
        rd_expect("R8 first status read", 8'h06);
        ev_rd(d, v);
        chk("R8 second status read no vld", v, 1'b0);
        ev_stop(ld);
    endtask

    task automatic t_unmapped;
        logic ld;
        write_one(8'h20, 8'h5A, ld);
        read_one("R9 unmapped reads zero", 8'h20, 8'h00);
        write_one(8'h21, 8'h6B, ld);
        ev_start(0); ev_addr(8'h1F); ev_start(1);
        rd_expect("R9 1Fh", 8'h00);
        ev_stop(ld);
        ev_start(1);
        rd_expect("R9 pointer advanced to 20h", 8'h00);
        ev_stop(ld);
        read_one("R9 unmapped write left control", 8'h10, 8'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_locked();
        t_status();
        t_wrap();
        t_nostop();
        t_snapshot();
        t_timeload();
        t_status_second();
        t_unmapped();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule